// File: doc/BRIEF.md
# Two-Port Memory with Mailbox Interrupts

This block is a two-port byte memory whose two highest addresses double as mailboxes for passing messages between the ports. The left and right ports each have a chip enable, an output enable, a write strobe, a busy input and an address. Either port can read or write any location at any time. The left port's mailbox is the next-to-last address and the right port's mailbox is the last address.

When one port writes into the other port's mailbox, the receiving port's active-low interrupt goes low. The receiving port drops the interrupt by accessing its own mailbox with chip enable and output enable both active. Mailbox bytes are ordinary storage: the message itself is just the byte stored there. When a port's busy input is high, that port's write is blocked and that port's access neither raises nor clears any interrupt. A parameter removes the interrupt logic completely. The memory then has no side effects at those two addresses.

All control signals are sampled on the rising clock edge. Stored data, read data and interrupt outputs change at that same edge.

Top module: `mbox_dpram`

## Requirements
- R1: After reset both interrupt outputs are high and both read-data outputs are zero.
- R2: A port with chip enable and write strobe high and busy low writes its data at its address. A port with chip enable and output enable high and write strobe low returns the byte at its address on read data one clock later. Read data holds its value in every other cycle.
- R3: A write attempted while the writing port's busy input is high leaves the memory unchanged.
- R4: A successful right-port write to the left mailbox (address DEPTH-2, 0x3FE by default) drives the left interrupt low from the next clock. A write by the left port to that address does not affect the left interrupt.
- R5: A successful left-port write to the right mailbox (address DEPTH-1, 0x3FF by default) drives the right interrupt low from the next clock.
- R6: A port clears its own interrupt (output returns high on the next clock) by accessing its own mailbox with chip enable and output enable high and busy low. The write strobe value does not matter.
- R7: An access made while that port's busy input is high neither sets nor clears any interrupt. An interrupt changes only on a set or clear event.
- R8: If a set and a clear of the same interrupt occur in the same cycle, the interrupt ends up asserted (low).
- R9: Mailbox bytes are stored and read back like any other location, including by the port that clears with that read.
- R10: With MBOX_EN = 0 both interrupts stay high permanently, and the mailbox addresses act as plain memory.
- R11: If both ports write one address in the same cycle, the left port's data is kept. A read of an address that the other port writes in the same cycle returns the old byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| l_ce | input | 1 | Left chip enable, active high |
| l_oe | input | 1 | Left output enable, active high |
| l_we | input | 1 | Left write strobe, active high |
| l_busy | input | 1 | Left busy; blocks left writes and left interrupt effects |
| l_addr | input | ADDR_W | Left address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data, registered |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_ce | input | 1 | Right chip enable, active high |
| r_oe | input | 1 | Right output enable, active high |
| r_we | input | 1 | Right write strobe, active high |
| r_busy | input | 1 | Right busy; blocks right writes and right interrupt effects |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data, registered |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
The bench builds two copies side by side with the default 10-bit address and 8-bit data. One copy has MBOX_EN = 1 and the other has MBOX_EN = 0, and both receive identical stimulus. This exposes the real mailbox addresses 0x3FE and 0x3FF, and each mailbox access can be compared between the interrupt copy and the plain-memory copy. Random traffic concentrates on the two mailboxes and a few low addresses, so set/clear collisions, busy-blocked events and same-address writes from both ports occur often.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int unsigned NPORT = 2;
  localparam int unsigned PL    = 0;
  localparam int unsigned PR    = 1;

  typedef enum logic [1:0] {
    FEV_HOLD  = 2'd0,
    FEV_CLEAR = 2'd1,
    FEV_SET   = 2'd2
  } flag_ev_e;

  // set has priority so a message arriving with a clear is not lost
  function automatic flag_ev_e flag_event(input logic set_req, input logic clr_req);
    if (set_req)      return FEV_SET;
    else if (clr_req) return FEV_CLEAR;
    else              return FEV_HOLD;
  endfunction

endpackage

// File: rtl/mbox_port_dec.sv
module mbox_port_dec #(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned OWN_MBOX  = 1022,
  parameter int unsigned PEER_MBOX = 1023
) (
  input  logic              ce,
  input  logic              oe,
  input  logic              we,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_go,
  output logic              rd_go,
  output logic              set_peer,
  output logic              clr_own
);

  localparam logic [ADDR_W-1:0] OWN_A  = ADDR_W'(OWN_MBOX);
  localparam logic [ADDR_W-1:0] PEER_A = ADDR_W'(PEER_MBOX);

  always_comb begin
    wr_go    = ce & we & ~busy;
    rd_go    = ce & oe & ~we;
    set_peer = wr_go & (addr == PEER_A);
    clr_own  = ce & oe & ~busy & (addr == OWN_A);
  end

endmodule

// File: rtl/mbox_flag.sv
module mbox_flag
  import mbox_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic irq_n
);

  logic     pend_q;
  logic     pend_d;
  logic     pend_en;
  flag_ev_e ev;

  always_comb begin
    ev      = flag_event(set_req, clr_req);
    pend_en = (ev != FEV_HOLD);
    pend_d  = (ev == FEV_SET);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign irq_n = ~pend_q;

endmodule

// File: rtl/mbox_mem.sv
module mbox_mem
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPORT-1:0]        wr_go,
  input  logic [NPORT-1:0]        rd_go,
  input  logic [NPORT-1:0][ADDR_W-1:0] addr,
  input  logic [NPORT-1:0][DATA_W-1:0] wdata,
  output logic [NPORT-1:0][DATA_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic [NPORT-1:0][DATA_W-1:0] rd_d;

  // right first, left last: left wins a same-address collision
  always_ff @(posedge clk) begin
    if (wr_go[PR]) store[addr[PR]] <= wdata[PR];
    if (wr_go[PL]) store[addr[PL]] <= wdata[PL];
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    always_comb rd_d[p] = store[addr[p]];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rdata[p] <= '0;
      else if (rd_go[p]) rdata[p] <= rd_d[p];
    end
  end

endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned DATA_W  = 8,
  parameter bit          MBOX_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_ce,
  input  logic              l_oe,
  input  logic              l_we,
  input  logic              l_busy,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_irq_n,
  input  logic              r_ce,
  input  logic              r_oe,
  input  logic              r_we,
  input  logic              r_busy,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_irq_n
);

  localparam int unsigned DEPTH   = 1 << ADDR_W;
  localparam int unsigned MB_LEFT = DEPTH - 2;
  localparam int unsigned MB_RGHT = DEPTH - 1;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NPORT-1:0]             ce_v, oe_v, we_v, busy_v;
  logic [NPORT-1:0][ADDR_W-1:0] addr_v;
  logic [NPORT-1:0][DATA_W-1:0] wdata_v, rdata_v;
  logic [NPORT-1:0]             wr_go, rd_go, set_peer, clr_own, irq_n_v;

  always_comb begin
    ce_v       = {r_ce, l_ce};
    oe_v       = {r_oe, l_oe};
    we_v       = {r_we, l_we};
    busy_v     = {r_busy, l_busy};
    addr_v     = {r_addr, l_addr};
    wdata_v    = {r_wdata, l_wdata};
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam int unsigned OWN  = (p == PL) ? MB_LEFT : MB_RGHT;
    localparam int unsigned PEER = (p == PL) ? MB_RGHT : MB_LEFT;

    mbox_port_dec #(
      .ADDR_W   (ADDR_W),
      .OWN_MBOX (OWN),
      .PEER_MBOX(PEER)
    ) dec_i (
      .ce      (ce_v[p]),
      .oe      (oe_v[p]),
      .we      (we_v[p]),
      .busy    (busy_v[p]),
      .addr    (addr_v[p]),
      .wr_go   (wr_go[p]),
      .rd_go   (rd_go[p]),
      .set_peer(set_peer[p]),
      .clr_own (clr_own[p])
    );

    if (MBOX_EN) begin : g_irq
      mbox_flag flag_i (
        .clk    (clk),
        .rst_n  (rst_int_n),
        .set_req(set_peer[NPORT-1-p]),
        .clr_req(clr_own[p]),
        .irq_n  (irq_n_v[p])
      );
    end else begin : g_noirq
      assign irq_n_v[p] = 1'b1;
    end
  end

  mbox_mem #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) mem_i (
    .clk  (clk),
    .rst_n(rst_int_n),
    .wr_go(wr_go),
    .rd_go(rd_go),
    .addr (addr_v),
    .wdata(wdata_v),
    .rdata(rdata_v)
  );

  assign l_rdata = rdata_v[PL];
  assign r_rdata = rdata_v[PR];
  assign l_irq_n = irq_n_v[PL];
  assign r_irq_n = irq_n_v[PR];

endmodule

// File: rtl/mbox_dpram_chk.sv
module mbox_dpram_chk #(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned DATA_W  = 8,
  parameter bit          MBOX_EN = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              l_ce,
  input logic              l_oe,
  input logic              l_we,
  input logic              l_busy,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_irq_n,
  input logic              r_ce,
  input logic              r_oe,
  input logic              r_we,
  input logic              r_busy,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_irq_n
);

  localparam logic [ADDR_W-1:0] MBL = ADDR_W'((1 << ADDR_W) - 2);
  localparam logic [ADDR_W-1:0] MBR = ADDR_W'((1 << ADDR_W) - 1);

  logic set_l, clr_l, set_r, clr_r;
  always_comb begin
    set_l = r_ce && r_we && !r_busy && (r_addr == MBL);
    clr_l = l_ce && l_oe && !l_busy && (l_addr == MBL);
    set_r = l_ce && l_we && !l_busy && (l_addr == MBR);
    clr_r = r_ce && r_oe && !r_busy && (r_addr == MBR);
  end

  if (MBOX_EN) begin : g_on
    assert_l_fall_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(l_irq_n) |-> $past(set_l));
    assert_r_fall_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(r_irq_n) |-> $past(set_r));
    assert_l_rise_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(l_irq_n) |-> $past(clr_l));
    assert_r_rise_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(r_irq_n) |-> $past(clr_r));
    assert_l_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_l && !clr_l) |=> $stable(l_irq_n));
    assert_r_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_r && !clr_r) |=> $stable(r_irq_n));
    assert_l_setwins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (set_l && clr_l) |=> !l_irq_n);
    assert_r_setwins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (set_r && clr_r) |=> !r_irq_n);
  end else begin : g_off
    assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (l_ce || r_ce) |=> (l_irq_n && r_irq_n));
  end

endmodule

bind mbox_dpram mbox_dpram_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .MBOX_EN(MBOX_EN)
) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .l_ce   (l_ce),
  .l_oe   (l_oe),
  .l_we   (l_we),
  .l_busy (l_busy),
  .l_addr (l_addr),
  .l_irq_n(l_irq_n),
  .r_ce   (r_ce),
  .r_oe   (r_oe),
  .r_we   (r_we),
  .r_busy (r_busy),
  .r_addr (r_addr),
  .r_irq_n(r_irq_n)
);

// File: tb/mbox_dpram_tb_top.sv
module mbox_dpram_tb_top;

  localparam int AW    = 10;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] MBL = AW'(DEPTH - 2);
  localparam logic [AW-1:0] MBR = AW'(DEPTH - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          l_ce = 0, l_oe = 0, l_we = 0, l_busy = 0;
  logic          r_ce = 0, r_oe = 0, r_we = 0, r_busy = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata, l_rdata_p, r_rdata_p;
  logic          l_irq_n, r_irq_n, l_irq_n_p, r_irq_n_p;

  mbox_dpram #(.ADDR_W(AW), .DATA_W(DW), .MBOX_EN(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .l_ce(l_ce), .l_oe(l_oe), .l_we(l_we), .l_busy(l_busy), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
    .r_ce(r_ce), .r_oe(r_oe), .r_we(r_we), .r_busy(r_busy), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n));

  mbox_dpram #(.ADDR_W(AW), .DATA_W(DW), .MBOX_EN(1'b0)) dut_plain_i (
    .clk(clk), .rst_n(rst_n),
    .l_ce(l_ce), .l_oe(l_oe), .l_we(l_we), .l_busy(l_busy), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata_p), .l_irq_n(l_irq_n_p),
    .r_ce(r_ce), .r_oe(r_oe), .r_we(r_we), .r_busy(r_busy), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata_p), .r_irq_n(r_irq_n_p));

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model
  logic [DW-1:0] m_mem [DEPTH];
  bit            m_ok  [DEPTH];
  bit            m_fl, m_fr;
  logic [DW-1:0] m_rl, m_rr;
  bit            m_rl_ok, m_rr_ok;
  string         cur_tag = "R2";
  string         tag_l = "R6", tag_r = "R6";

  function automatic string ev_tag(bit set, bit clr, bit blocked, bit is_left);
    if (set && clr) return "R8";
    if (set)        return is_left ? "R4" : "R5";
    if (clr)        return "R6";
    if (blocked)    return "R7";
    return "R6";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit wl, wr, sl, cl, sr, cr, bl, br;
    wl = l_ce && l_we && !l_busy;
    wr = r_ce && r_we && !r_busy;
    if (l_ce && l_oe && !l_we) begin m_rl = m_mem[l_addr]; m_rl_ok = m_ok[l_addr]; end
    if (r_ce && r_oe && !r_we) begin m_rr = m_mem[r_addr]; m_rr_ok = m_ok[r_addr]; end
    if (wr) begin m_mem[r_addr] = r_wdata; m_ok[r_addr] = 1; end
    if (wl) begin m_mem[l_addr] = l_wdata; m_ok[l_addr] = 1; end
    sl = wr && r_addr == MBL;
    cl = l_ce && l_oe && !l_busy && l_addr == MBL;
    bl = (r_ce && r_we && r_busy && r_addr == MBL) || (l_ce && l_oe && l_busy && l_addr == MBL);
    sr = wl && l_addr == MBR;
    cr = r_ce && r_oe && !r_busy && r_addr == MBR;
    br = (l_ce && l_we && l_busy && l_addr == MBR) || (r_ce && r_oe && r_busy && r_addr == MBR);
    tag_l = ev_tag(sl, cl, bl, 1);
    tag_r = ev_tag(sr, cr, br, 0);
    if (sl) m_fl = 1; else if (cl) m_fl = 0;
    if (sr) m_fr = 1; else if (cr) m_fr = 0;
  endtask

  task automatic cycle();
    model_step();
    @(posedge clk);
    #1;
    chk(tag_l, 32'(l_irq_n), 32'(!m_fl), "left irq_n");
    chk(tag_r, 32'(r_irq_n), 32'(!m_fr), "right irq_n");
    chk("R10", 32'({l_irq_n_p, r_irq_n_p}), 32'(2'b11), "plain irq_n pair");
    if (m_rl_ok) begin
      chk(cur_tag, 32'(l_rdata), 32'(m_rl), "left rdata");
      chk("R10", 32'(l_rdata_p), 32'(m_rl), "plain left rdata");
    end
    if (m_rr_ok) begin
      chk(cur_tag, 32'(r_rdata), 32'(m_rr), "right rdata");
      chk("R10", 32'(r_rdata_p), 32'(m_rr), "plain right rdata");
    end
  endtask

  task automatic idle();
    l_ce = 0; l_oe = 0; l_we = 0; l_busy = 0;
    r_ce = 0; r_oe = 0; r_we = 0; r_busy = 0;
  endtask

  task automatic lacc(bit ce, bit oe, bit we, bit busy, logic [AW-1:0] a, logic [DW-1:0] d);
    l_ce = ce; l_oe = oe; l_we = we; l_busy = busy; l_addr = a; l_wdata = d;
  endtask

  task automatic racc(bit ce, bit oe, bit we, bit busy, logic [AW-1:0] a, logic [DW-1:0] d);
    r_ce = ce; r_oe = oe; r_we = we; r_busy = busy; r_addr = a; r_wdata = d;
  endtask

  function automatic logic [AW-1:0] pick_addr();
    int k = int'($urandom_range(0, 9));
    if (k < 3) return MBL;
    if (k < 6) return MBR;
    return AW'($urandom_range(0, 7));
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < DEPTH; i++) begin m_ok[i] = 0; m_mem[i] = '0; end
    m_fl = 0; m_fr = 0; m_rl = '0; m_rr = '0; m_rl_ok = 1; m_rr_ok = 1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", 32'(l_irq_n), 32'd1, "left irq_n in reset");
    chk("R1", 32'(r_irq_n), 32'd1, "right irq_n in reset");
    chk("R1", 32'(l_rdata), 32'd0, "left rdata in reset");
    chk("R1", 32'(r_rdata), 32'd0, "right rdata in reset");
    rst_n = 1;
    repeat (4) cycle();

    // R2 fill memory from both ports
    cur_tag = "R2";
    for (int i = 0; i < DEPTH / 2; i++) begin
      lacc(1, 0, 1, 0, AW'(i), DW'($urandom));
      racc(1, 0, 1, 0, AW'(i + DEPTH / 2), DW'($urandom));
      cycle();
    end
    // right wrote 0x3FE during fill: left flag raised; left clears it
    idle(); lacc(1, 1, 0, 0, MBL, '0); cycle();
    idle(); lacc(1, 1, 0, 0, 8'd5, '0); racc(1, 1, 0, 0, 10'd600, '0); cycle();

    // R5 + R9: left posts 0xA5 to right mailbox, right reads and clears
    cur_tag = "R9";
    idle(); lacc(1, 0, 1, 0, MBR, 8'hA5); cycle();
    idle(); cycle();
    idle(); racc(1, 1, 0, 0, MBR, '0); cycle();
    idle(); cycle();

    // R3 + R7: busy right write to left mailbox: no data, no flag
    cur_tag = "R3";
    idle(); racc(1, 0, 1, 1, MBL, 8'h3C); cycle();
    idle(); lacc(1, 0, 0, 1, MBL, '0); cycle();
    idle(); racc(1, 1, 0, 0, MBL, '0); cycle();

    // R8 + R11: set and clear together, left reads old byte
    cur_tag = "R11";
    idle(); racc(1, 0, 1, 0, MBL, 8'h5A); lacc(1, 1, 0, 0, MBL, '0); cycle();
    idle(); cycle();
    // R7: clear attempt while left busy
    idle(); lacc(1, 1, 0, 1, MBL, '0); cycle();
    // R6: clear with write strobe high (write to own mailbox)
    idle(); lacc(1, 1, 1, 0, MBL, 8'h77); cycle();
    idle(); racc(1, 1, 0, 0, MBL, '0); cycle();
    // R11: both write same address, left wins
    idle(); lacc(1, 0, 1, 0, 10'd9, 8'h11); racc(1, 0, 1, 0, 10'd9, 8'h22); cycle();
    idle(); racc(1, 1, 0, 0, 10'd9, '0); lacc(1, 1, 0, 0, 10'd9, '0); cycle();

    // random phase
    cur_tag = "R2";
    for (int n = 0; n < 4000; n++) begin
      lacc($urandom_range(0, 9) < 8, $urandom_range(0, 9) < 6, $urandom_range(0, 9) < 4,
           $urandom_range(0, 9) < 1, pick_addr(), DW'($urandom));
      racc($urandom_range(0, 9) < 8, $urandom_range(0, 9) < 6, $urandom_range(0, 9) < 4,
           $urandom_range(0, 9) < 1, pick_addr(), DW'($urandom));
      cycle();
    end
    idle(); cycle();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule